// File: doc/BRIEF.md
# Dual-Context Cell-Update Interleaver

This block lets one pipelined cell-update unit serve two independent record streams, one from each of two memory units, so that one physical arithmetic pipeline acts as two virtual processors. Each record carries a cell state made of two halves, a cell area value and three neighbour-connectivity descriptors. A free-running phase bit splits time into even and odd cycles. The first context may issue only on even cycles and the second only on odd cycles. A one-bit tag travels with each operand through a fixed-latency pipeline, and each result is delivered only to the context that issued it.

In a system, the second context runs the next time iteration of the same cell stream. Its memory unit reads back the states written by the first context and returns them one step further on. Because of this, the pipeline advances two time iterations per pass over the data without any wider input stream. The arithmetic datapath is a stub: the new high half is the old high half plus the area and the first descriptor, and the new low half is the old low half plus the second and third descriptors, all modulo the half width.

Every data interface is valid/ready. A record is transferred on a rising edge where both valid and ready are high. The source must hold valid and its data steady until that edge. The sink may lower ready at any time. Each context has its own output queue and its own credit count, so back-pressure on one context never blocks or disturbs the other.

Top module: `dcmi_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `phase_odd` is 0 and both `out_valid` bits are 0.
- R2: Context 0 (bit 0 of each per-context vector) is accepted only in cycles where `phase_odd` is 0, and context 1 (bit 1) only where `phase_odd` is 1. An empty slot issues a bubble and is never given to the other context.
- R3: After reset, `phase_odd` inverts on every rising clock edge.
- R4: A result equals {hi + area + d0, lo + d1 + d2}, each half taken modulo 2^SW. Here `in_state` per context holds {hi, lo} with hi in the upper SW bits, and `in_desc` holds {d2, d1, d0} with d0 in the lowest DESC_W bits. With the queue empty and `out_ready` high, the result's `out_valid` rises LAT edges after the edge that accepted the record.
- R5: A result appears only on the output of the context that issued it.
- R6: While `out_valid` is high and `out_ready` is low for a context, that context's `out_valid` and `out_state` stay unchanged on the next cycle.
- R7: A context whose output is stalled does not stop, reorder or alter the records of the other context.
- R8: A context holds at most DEPTH records, counting those in flight and those queued. Once it holds DEPTH records, its `in_ready` stays low until one of them is taken from its output.
- R9: Each context delivers its results in the order it accepted the records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Record valid, one bit per context |
| in_ready | output | 2 | Record ready, one bit per context |
| in_state | input | 2*2*SW | Per-context state {hi, lo}; context c at bits [c*2*SW +: 2*SW] |
| in_area | input | 2*AREA_W | Per-context cell area |
| in_desc | input | 2*3*DESC_W | Per-context descriptors {d2, d1, d0} |
| out_valid | output | 2 | Result valid, one bit per context |
| out_ready | input | 2 | Result ready, one bit per context |
| out_state | output | 2*2*SW | Per-context new state {hi, lo} |
| phase_odd | output | 1 | Current slot: 0 even (context 0), 1 odd (context 1) |

## Verification
Two things can happen in the same cycle: a result retiring from the shared pipeline into one context's queue, and the other context issuing a new record or popping its own queue. The same collision occurs within one context when a retirement meets a pop. The bench provokes it by streaming both contexts at once under a sweep of staggered and stalled ready patterns. It judges the outcome with a per-context scoreboard of arithmetically computed results, together with checks on slot phase, hold stability, credit limit and latency.

// File: rtl/dcmi_pkg.sv
package dcmi_pkg;
  localparam int NUM_CTX = 2;

  typedef enum logic {
    CTX_EVEN = 1'b0,
    CTX_ODD  = 1'b1
  } ctx_e;
endpackage

// File: rtl/dcmi_phase.sv
module dcmi_phase (
  input  logic clk,
  input  logic rst_n,
  output logic phase_odd
);
  // Slot owner alternates every cycle; the even slot comes first after reset.
  always_ff @(posedge clk) begin
    if (!rst_n) phase_odd <= dcmi_pkg::CTX_EVEN;
    else        phase_odd <= ~phase_odd;
  end
endmodule

// File: rtl/dcmi_au_stub.sv
module dcmi_au_stub #(
  parameter int SW     = 16,
  parameter int AREA_W = 8,
  parameter int DESC_W = 8,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_tag,
  input  logic [2*SW-1:0]   in_state,
  input  logic [AREA_W-1:0] in_area,
  input  logic [3*DESC_W-1:0] in_desc,
  output logic              out_valid,
  output logic              out_tag,
  output logic [2*SW-1:0]   out_state
);
  logic [SW-1:0]     new_hi, new_lo;
  logic [LAT-1:0]    v_q;
  logic [LAT-1:0]    t_q;
  logic [2*SW-1:0]   s_q [LAT];

  // Stand-in for the floating-point cell update.
  always_comb begin
    new_hi = in_state[2*SW-1:SW] + SW'(in_area) + SW'(in_desc[DESC_W-1:0]);
    new_lo = in_state[SW-1:0] + SW'(in_desc[2*DESC_W-1:DESC_W])
           + SW'(in_desc[3*DESC_W-1:2*DESC_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      v_q[0] <= in_valid;
      for (int i = 1; i < LAT; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    t_q[0] <= in_tag;
    s_q[0] <= {new_hi, new_lo};
    for (int i = 1; i < LAT; i++) begin
      t_q[i] <= t_q[i-1];
      s_q[i] <= s_q[i-1];
    end
  end

  assign out_valid = v_q[LAT-1];
  assign out_tag   = t_q[LAT-1];
  assign out_state = s_q[LAT-1];
endmodule

// File: rtl/dcmi_ctx_port.sv
module dcmi_ctx_port #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         phase_match,
  input  logic         in_valid,
  output logic         in_ready,
  output logic         accept,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] credit_q, occ_q;
  logic [AW-1:0] wptr_q, rptr_q;
  logic [W-1:0]  mem_q [DEPTH];
  logic          pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // Credits cover records in flight plus queued, so the queue cannot overflow.
  assign in_ready  = phase_match && (credit_q < CW'(DEPTH));
  assign accept    = in_valid && in_ready;
  assign out_valid = (occ_q != '0);
  assign pop       = out_valid && out_ready;
  assign out_data  = mem_q[rptr_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_q <= '0;
      occ_q    <= '0;
      wptr_q   <= '0;
      rptr_q   <= '0;
    end else begin
      credit_q <= credit_q + CW'(accept) - CW'(pop);
      occ_q    <= occ_q + CW'(wr_en) - CW'(pop);
      if (wr_en) wptr_q <= step(wptr_q);
      if (pop)   rptr_q <= step(rptr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wptr_q] <= wr_data;
  end
endmodule

// File: rtl/dcmi_top.sv
module dcmi_top
  import dcmi_pkg::*;
#(
  parameter int SW     = 16,
  parameter int AREA_W = 8,
  parameter int DESC_W = 8,
  parameter int LAT    = 3,
  parameter int DEPTH  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CTX-1:0]          in_valid,
  output logic [NUM_CTX-1:0]          in_ready,
  input  logic [NUM_CTX*2*SW-1:0]     in_state,
  input  logic [NUM_CTX*AREA_W-1:0]   in_area,
  input  logic [NUM_CTX*3*DESC_W-1:0] in_desc,
  output logic [NUM_CTX-1:0]          out_valid,
  input  logic [NUM_CTX-1:0]          out_ready,
  output logic [NUM_CTX*2*SW-1:0]     out_state,
  output logic                        phase_odd
);
  localparam int RW = 2 * SW;
  localparam int DW = 3 * DESC_W;

  logic [NUM_CTX-1:0] accept;
  logic               au_v, au_tag;
  logic [RW-1:0]      au_state;
  logic [RW-1:0]      iss_state;
  logic [AREA_W-1:0]  iss_area;
  logic [DW-1:0]      iss_desc;

  dcmi_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_odd (phase_odd)
  );

  // Only the slot owner can be accepted, so the phase picks the operand.
  always_comb begin
    iss_state = in_state[(phase_odd ? RW : 0) +: RW];
    iss_area  = in_area[(phase_odd ? AREA_W : 0) +: AREA_W];
    iss_desc  = in_desc[(phase_odd ? DW : 0) +: DW];
  end

  dcmi_au_stub #(
    .SW(SW), .AREA_W(AREA_W), .DESC_W(DESC_W), .LAT(LAT)
  ) u_au (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (|accept),
    .in_tag    (phase_odd),
    .in_state  (iss_state),
    .in_area   (iss_area),
    .in_desc   (iss_desc),
    .out_valid (au_v),
    .out_tag   (au_tag),
    .out_state (au_state)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    dcmi_ctx_port #(.W(RW), .DEPTH(DEPTH)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_match (phase_odd == 1'(c)),
      .in_valid    (in_valid[c]),
      .in_ready    (in_ready[c]),
      .accept      (accept[c]),
      .wr_en       (au_v && (au_tag == 1'(c))),
      .wr_data     (au_state),
      .out_valid   (out_valid[c]),
      .out_ready   (out_ready[c]),
      .out_data    (out_state[c*RW +: RW])
    );
  end
endmodule

// File: rtl/dcmi_chk.sv
module dcmi_chk #(
  parameter int SW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      in_valid,
  input logic [1:0]      in_ready,
  input logic [1:0]      out_valid,
  input logic [1:0]      out_ready,
  input logic [4*SW-1:0] out_state,
  input logic            phase_odd
);
  a_r2_even_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid[0] && in_ready[0]) |-> !phase_odd);

  a_r2_odd_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid[1] && in_ready[1]) |-> phase_odd);

  a_r3_even_to_odd: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_odd |=> phase_odd);

  a_r3_odd_to_even: assert property (@(posedge clk) disable iff (!rst_n)
    phase_odd |=> !phase_odd);

  a_r6_hold_ctx0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[0] && !out_ready[0]) |=>
      (out_valid[0] && $stable(out_state[2*SW-1:0])));

  a_r6_hold_ctx1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[1] && !out_ready[1]) |=>
      (out_valid[1] && $stable(out_state[4*SW-1:2*SW])));
endmodule

bind dcmi_top dcmi_chk #(.SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_state (out_state),
  .phase_odd (phase_odd)
);

// File: tb/tb_dcmi_top.sv
`timescale 1ns/1ps
module tb_dcmi_top;
  localparam int SW = 16, LAT = 3, DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  in_valid = '0;
  logic [1:0]  in_ready;
  logic [63:0] in_state = '0;
  logic [15:0] in_area = '0;
  logic [47:0] in_desc = '0;
  logic [1:0]  out_valid;
  logic [1:0]  out_ready = '0;
  logic [63:0] out_state;
  logic        phase_odd;

  int tests = 0, fails = 0, cyc = 0;
  int rmode [2] = '{0, 0};
  int acc_cyc [2] = '{0, 0};
  int rise_cyc [2] = '{0, 0};
  int pops [2] = '{0, 0};
  int accs [2] = '{0, 0};
  logic [31:0] expq0 [$];
  logic [31:0] expq1 [$];
  logic        prev_hold [2] = '{1'b0, 1'b0};
  logic        prev_ov [2] = '{1'b0, 1'b0};
  logic [31:0] prev_dat [2];
  logic        prev_ph = 1'b0;
  logic        ph_seen = 1'b0;

  always #4 clk = ~clk;

  dcmi_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_state(in_state), .in_area(in_area), .in_desc(in_desc),
    .out_valid(out_valid), .out_ready(out_ready), .out_state(out_state),
    .phase_odd(phase_odd)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [15:0] hi, lo,
                                        input logic [7:0] a, d0, d1, d2);
    logic [15:0] nh, nl;
    nh = hi + 16'(a) + 16'(d0);
    nl = lo + 16'(d1) + 16'(d2);
    return {nh, nl};
  endfunction

  // Monitor: samples between edges.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ph_seen) chk(phase_odd != prev_ph, "R3 phase flip", 32'(phase_odd), 32'(!prev_ph));
      prev_ph = phase_odd;
      ph_seen = 1'b1;
      for (int c = 0; c < 2; c++) begin
        if (in_valid[c] && in_ready[c]) begin
          chk(phase_odd == 1'(c), "R2 slot phase", 32'(phase_odd), 32'(c));
          acc_cyc[c] = cyc;
          accs[c]++;
          if (c == 0) expq0.push_back(model(in_state[31:16], in_state[15:0], in_area[7:0],
                                            in_desc[7:0], in_desc[15:8], in_desc[23:16]));
          else        expq1.push_back(model(in_state[63:48], in_state[47:32], in_area[15:8],
                                            in_desc[31:24], in_desc[39:32], in_desc[47:40]));
        end
        if (prev_hold[c])
          chk(out_valid[c] && out_state[c*32 +: 32] == prev_dat[c], "R6 hold under stall",
              out_state[c*32 +: 32], prev_dat[c]);
        if (out_valid[c] && !prev_ov[c]) rise_cyc[c] = cyc;
        if (out_valid[c] && out_ready[c]) begin
          logic [31:0] e;
          pops[c]++;
          if ((c == 0 && expq0.size() == 0) || (c == 1 && expq1.size() == 0)) begin
            chk(1'b0, "R5 result on non-issuing context", out_state[c*32 +: 32], 32'h0);
          end else begin
            e = (c == 0) ? expq0.pop_front() : expq1.pop_front();
            chk(out_state[c*32 +: 32] == e, "R4/R9 result value and order",
                out_state[c*32 +: 32], e);
          end
        end
        prev_hold[c] = out_valid[c] && !out_ready[c];
        prev_dat[c]  = out_state[c*32 +: 32];
        prev_ov[c]   = out_valid[c];
      end
    end
  end

  // Output ready patterns.
  initial begin
    forever begin
      @(posedge clk); #1;
      for (int c = 0; c < 2; c++) begin
        case (rmode[c])
          0: out_ready[c] = 1'b1;
          1: out_ready[c] = 1'b0;
          2: out_ready[c] = ((cyc + c) % 3) != 0;
          default: out_ready[c] = (cyc % 4) < 2;
        endcase
      end
    end
  end

  task automatic send(input int c, input logic [15:0] hi, lo,
                      input logic [7:0] a, d0, d1, d2);
    @(posedge clk); #1;
    in_state[c*32 +: 32] = {hi, lo};
    in_area[c*8 +: 8]    = a;
    in_desc[c*24 +: 24]  = {d2, d1, d0};
    in_valid[c] = 1'b1;
    do @(negedge clk); while (!in_ready[c]);
    @(posedge clk); #1;
    in_valid[c] = 1'b0;
  endtask

  task automatic stream(input int c, input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      int v;
      v = seed * 31 + k;
      send(c, 16'(v * 4099) ^ 16'hFF00, 16'(v * 257 + c), 8'(v * 13), 8'(v),
           ~8'(v), 8'(v * 5));
    end
  endtask

  task automatic drain();
    rmode[0] = 0; rmode[1] = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (expq0.size() == 0 && expq1.size() == 0 && out_valid == 2'b00) break;
    end
    chk(expq0.size() == 0 && expq1.size() == 0, "R9 all results delivered",
        32'(expq0.size() + expq1.size()), 32'h0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 2'b00 && phase_odd == 1'b0, "R1 in reset",
        {30'h0, out_valid} | 32'(phase_odd) << 4, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 2'b00 && phase_odd == 1'b0, "R1 after release",
        {30'h0, out_valid} | 32'(phase_odd) << 4, 32'h0);

    // R4 latency: single record on context 0, all ready.
    repeat (4) @(negedge clk);
    send(0, 16'h1234, 16'hFFFF, 8'h05, 8'h10, 8'h01, 8'h02);
    repeat (LAT + 3) @(negedge clk);
    chk(rise_cyc[0] - acc_cyc[0] == LAT + 1, "R4 latency", 32'(rise_cyc[0] - acc_cyc[0]),
        32'(LAT + 1));
    chk(pops[1] == 0 && out_valid[1] == 1'b0, "R5 other context untouched",
        32'(pops[1]), 32'h0);

    // R4 wrap: maximum values on context 1.
    send(1, 16'hFFFF, 16'hFFFE, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    repeat (LAT + 3) @(negedge clk);
    chk(pops[1] == 1, "R5 context 1 result routed", 32'(pops[1]), 32'h1);

    // Sweep of ready patterns with both contexts streaming.
    for (int m0 = 0; m0 < 4; m0++) begin
      for (int m1 = 0; m1 < 4; m1++) begin
        if (m0 == 1 || m1 == 1) continue;
        rmode[0] = m0; rmode[1] = m1;
        fork
          stream(0, 12, m0 * 4 + m1);
          stream(1, 12, m0 * 4 + m1 + 50);
        join
        drain();
      end
    end

    // R7/R8: context 0 stalled while context 1 keeps flowing.
    begin
      int p1, a0;
      rmode[0] = 1; rmode[1] = 0;
      p1 = pops[1]; a0 = accs[0];
      fork
        stream(0, DEPTH, 7);
        stream(1, 6, 9);
      join
      @(posedge clk); #1;
      in_state[31:0] = 32'hABCD_0123; in_area[7:0] = 8'h11; in_desc[23:0] = 24'h030201;
      in_valid[0] = 1'b1;
      repeat (2 * LAT + 6) @(negedge clk);
      if (phase_odd) @(negedge clk);
      chk(in_ready[0] == 1'b0, "R8 credit limit blocks", 32'(in_ready[0]), 32'h0);
      chk(accs[0] - a0 == DEPTH, "R8 accepted count", 32'(accs[0] - a0), 32'(DEPTH));
      repeat (LAT + 2) @(negedge clk);
      chk(pops[1] - p1 == 6, "R7 other context flows", 32'(pops[1] - p1), 32'h6);
      chk(out_valid[0] == 1'b1, "R6 stalled output held", 32'(out_valid[0]), 32'h1);
      rmode[0] = 0;
      do @(negedge clk); while (!in_ready[0]);
      @(posedge clk); #1 in_valid[0] = 1'b0;
      drain();
      chk(accs[0] - a0 == DEPTH + 1, "R8 held record accepted after release",
          32'(accs[0] - a0), 32'(DEPTH + 1));
    end

    finish_run();
  end
endmodule